// File: doc/BRIEF.md
# Auto-Reload Timer with Watchdog Mode

This block is an 8-bit up-counter that serves two purposes, selected by a mode bit in its control register. In timer mode, a run bit lets the counter advance by one on each count tick. The ticks come from an external prescaler. When the counter passes FFh, it takes the value of the reload register and produces a one-cycle interrupt pulse. Software can write the counter directly in this mode.

Setting the mode bit turns the block into a watchdog. Software cannot clear the mode bit again; only the system reset returns the block to timer mode. In watchdog mode the counter cannot be written directly. A write to the counter address with low nibble 3h starts the count. From then on, software must write a low nibble of Ch and then a low nibble of 3h to reload the counter. If a tick carries the counter past FFh first, the block raises a one-cycle system-reset request. The prescaler, the CPU and the reset handling are outside the block.

The write bus is a plain register port with one write per enabled cycle and no back-pressure. Every write is taken in the cycle it is presented, so the bus has no valid/ready handshake.

Top module: `wdt_reload_timer`

## Requirements
- R1: After reset, the counter reads 00h and the reload register holds 00h. Both mode bits are 0, both pulse outputs are low, and the watchdog key state waits for a start key.
- R2: In timer mode with the run bit (control bit 0) at 1, each cycle with `tick_i` high adds one to the counter. With the run bit at 0, or with no tick, the counter holds.
- R3: In timer mode, a tick while the counter is FFh raises `irq_o` for that cycle, and the counter then holds the reload value.
- R4: In timer mode, a counter write (`wr_sel_i` = 2) loads `wr_data_i` into the counter. The write takes priority over a tick in the same cycle, and no interrupt is raised in that cycle.
- R5: Writing control bit 1 as 1 selects watchdog mode. A later control write with bit 1 at 0 does not leave it; only reset does.
- R6: In watchdog mode, the counter does not move until a counter-address write with low nibble 3h starts it. The upper nibble of that write is ignored. Once started, the counter advances on every tick.
- R7: After the start, a counter-address write with low nibble Ch, followed by one with low nibble 3h, loads the reload value into the counter.
- R8: In watchdog mode, a counter-address write that does not match the expected next key is ignored, and the sequence again expects Ch. For example, the writes C, 5, 3 do not reload the counter.
- R9: In watchdog mode, the data of a counter-address write never reaches the counter.
- R10: In watchdog mode, a tick while the counter is FFh raises `wdt_rst_o` for that cycle, and `irq_o` stays low. The timeout after a service is therefore 256 − R ticks.
- R11: In watchdog mode, the run bit has no effect on counting.
- R12: If the key pair completes in the same cycle as a tick that would overflow, the reload takes place and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| tick_i | input | 1 | One-cycle count tick from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1 reload, 2 counter, 3 none |
| wr_data_i | input | 8 | Write data (control: bit 0 run, bit 1 watchdog mode) |
| irq_o | output | 1 | Timer overflow interrupt pulse |
| wdt_rst_o | output | 1 | Watchdog system-reset request pulse |
| count_o | output | 8 | Counter readback |

## Verification
The assertions check the following on every cycle:
- the watchdog mode latch stays set once set;
- the counter holds the old reload value after each overflow;
- the counter advances by one on each ordinary tick;
- the counter holds in watchdog mode when no tick and no service occur;
- the two pulse outputs are never high together, and the reset request appears only in watchdog mode;
- the key sequence never falls back to waiting for a start.

Some behaviours depend on a sequence of writes, so only the bench scenarios can show them:
- the order of the key writes, including recovery after a mismatch;
- the exact 256 − R tick timeout;
- the priority of a service over an overflow in the same cycle;
- the priority of a timer-mode write over a tick in the same cycle.

// File: rtl/wdtm_pkg.sv
package wdtm_pkg;
  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_RELOAD = 2'd1;
  localparam logic [1:0] SEL_COUNT  = 2'd2;

  localparam logic [3:0] KEY_GO  = 4'h3;
  localparam logic [3:0] KEY_ARM = 4'hC;

  typedef enum logic [1:0] {
    KS_IDLE   = 2'd0,
    KS_WANT_C = 2'd1,
    KS_WANT_3 = 2'd2
  } key_state_e;
endpackage

// File: rtl/wdtm_ctrl.sv
module wdtm_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_wr_i,
  input  logic         reload_wr_i,
  input  logic [W-1:0] data_i,
  output logic         run_o,
  output logic         wdt_mode_o,
  output logic [W-1:0] reload_o
);
  logic         run_q, wdt_q;
  logic [W-1:0] reload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      wdt_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      if (ctrl_wr_i) begin
        run_q <= data_i[0];
        wdt_q <= wdt_q | data_i[1];
      end
      if (reload_wr_i) reload_q <= data_i;
    end
  end

  assign run_o      = run_q;
  assign wdt_mode_o = wdt_q;
  assign reload_o   = reload_q;

  // R5
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_q |=> wdt_q);
endmodule

// File: rtl/wdtm_keyseq.sv
module wdtm_keyseq
  import wdtm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr_i,
  input  logic [3:0] key_i,
  output logic       started_o,
  output logic       service_o
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    service_o = 1'b0;
    if (key_wr_i) begin
      unique case (st_q)
        KS_IDLE:   if (key_i == KEY_GO) st_d = KS_WANT_C;
        KS_WANT_C: st_d = (key_i == KEY_ARM) ? KS_WANT_3 : KS_WANT_C;
        KS_WANT_3: begin
          st_d      = KS_WANT_C;
          service_o = (key_i == KEY_GO);
        end
        default:   st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign started_o = (st_q != KS_IDLE);

  // R8
  key_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started_o |=> started_o);
  // R7
  service_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    service_o |-> (st_q == KS_WANT_3));
endmodule

// File: rtl/wdtm_counter.sv
module wdtm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         count_en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         service_i,
  input  logic [W-1:0] reload_i,
  input  logic         wdt_mode_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         at_top, step;

  assign at_top = &cnt_q;
  assign step   = tick_i && count_en_i;
  assign ovf_o  = step && at_top && !load_i && !service_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (load_i)    cnt_q <= load_val_i;
    else if (service_i) cnt_q <= reload_i;
    else if (step)      cnt_q <= at_top ? reload_i : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R3
  ovf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (cnt_q == $past(reload_i)));
  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_top && !load_i && !service_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R9
  wdt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_mode_i && !service_i && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_reload_timer.sv
module wdt_reload_timer
  import wdtm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic         irq_o,
  output logic         wdt_rst_o,
  output logic [W-1:0] count_o
);
  logic         run, wdt_mode, started, service, ovf;
  logic         cnt_wr;
  logic [W-1:0] reload;

  assign cnt_wr = wr_en_i && (wr_sel_i == SEL_COUNT);

  wdtm_ctrl #(.W(W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr_i   (wr_en_i && (wr_sel_i == SEL_CTRL)),
    .reload_wr_i (wr_en_i && (wr_sel_i == SEL_RELOAD)),
    .data_i      (wr_data_i),
    .run_o       (run),
    .wdt_mode_o  (wdt_mode),
    .reload_o    (reload)
  );

  wdtm_keyseq u_keys (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_wr_i  (cnt_wr && wdt_mode),
    .key_i     (wr_data_i[3:0]),
    .started_o (started),
    .service_o (service)
  );

  wdtm_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .count_en_i (wdt_mode ? started : run),
    .load_i     (cnt_wr && !wdt_mode),
    .load_val_i (wr_data_i),
    .service_i  (service),
    .reload_i   (reload),
    .wdt_mode_i (wdt_mode),
    .cnt_o      (count_o),
    .ovf_o      (ovf)
  );

  assign irq_o     = ovf && !wdt_mode;
  assign wdt_rst_o = ovf && wdt_mode;

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && wdt_rst_o));
  // R10
  rst_only_wdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> wdt_mode);
endmodule

// File: tb/wdt_reload_timer_test.sv
`timescale 1ns/1ps
module wdt_reload_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd3;
  logic [7:0] wr_data_i = 8'h00;
  logic       irq_o, wdt_rst_o;
  logic [7:0] count_o;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .irq_o(irq_o),
    .wdt_rst_o(wdt_rst_o), .count_o(count_o));

  // vector: {wr, sel[1:0], data[7:0], tick, exp_irq, exp_cnt[7:0]}
  localparam int NV = 17;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 2'd1, 8'hFD, 1'b0, 1'b0, 8'h00},
    {1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 8'h00},
    {1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 8'h00},
    {1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 8'h01},
    {1'b0, 2'd3, 8'h00, 1'b0, 1'b0, 8'h01},
    {1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 8'h02},
    {1'b1, 2'd2, 8'hFE, 1'b0, 1'b0, 8'hFE},
    {1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 8'hFF},
    {1'b0, 2'd3, 8'h00, 1'b1, 1'b1, 8'hFD},
    {1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 8'hFE},
    {1'b1, 2'd2, 8'h10, 1'b1, 1'b0, 8'h10},
    {1'b1, 2'd0, 8'h00, 1'b0, 1'b0, 8'h10},
    {1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 8'h10},
    {1'b1, 2'd2, 8'hFF, 1'b0, 1'b0, 8'hFF},
    {1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 8'hFF},
    {1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 8'hFF},
    {1'b0, 2'd3, 8'h00, 1'b1, 1'b1, 8'hFD}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle: drive after negedge, check pulses before edge, count after edge.
  task automatic step(input logic wr, input logic [1:0] sel, input logic [7:0] d,
                      input logic tk, input logic e_irq, input logic e_rst,
                      input logic [7:0] e_cnt, input string tag);
    wr_en_i = wr; wr_sel_i = sel; wr_data_i = d; tick_i = tk;
    #1;
    check({tag, " irq"}, {7'd0, irq_o}, {7'd0, e_irq});
    check({tag, " rst"}, {7'd0, wdt_rst_o}, {7'd0, e_rst});
    @(negedge clk);
    wr_en_i = 1'b0; wr_sel_i = 2'd3; tick_i = 1'b0;
    check({tag, " cnt"}, count_o, e_cnt);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 count", count_o, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    check("R1 rst", {7'd0, wdt_rst_o}, 8'h00);

    // R2 R3 R4 timer-mode vector walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][20], VEC[i][19:18], VEC[i][17:10], VEC[i][9], VEC[i][8], 1'b0,
           VEC[i][7:0], $sformatf("R2/R3/R4 vec%0d", i));
    end

    // R1 reload register is 00h after reset
    do_reset();
    step(1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00, "R1 run");
    step(1'b1, 2'd2, 8'hFF, 1'b0, 1'b0, 1'b0, 8'hFF, "R1 load");
    step(1'b0, 2'd3, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, "R1 reload00");

    // Watchdog mode
    do_reset();
    step(1'b1, 2'd1, 8'hF0, 1'b0, 1'b0, 1'b0, 8'h00, "R10 reload");
    step(1'b1, 2'd0, 8'h02, 1'b0, 1'b0, 1'b0, 8'h00, "R5 enter");
    step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, "R6 idle tick");
    step(1'b1, 2'd2, 8'hA5, 1'b0, 1'b0, 1'b0, 8'h00, "R6 nonkey");
    step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, "R6 still idle");
    step(1'b1, 2'd2, 8'h83, 1'b0, 1'b0, 1'b0, 8'h00, "R9 start no load");
    step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0, 8'h01, "R6 counting");
    step(1'b1, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, "R5 clear try");
    step(1'b1, 2'd2, 8'h42, 1'b0, 1'b0, 1'b0, 8'h01, "R5 R9 still wdt");
    step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0, 8'h02, "R11 run ignored");
    step(1'b1, 2'd2, 8'h1C, 1'b0, 1'b0, 1'b0, 8'h02, "R7 arm");
    step(1'b1, 2'd2, 8'hF3, 1'b0, 1'b0, 1'b0, 8'hF0, "R7 service");
    for (int k = 0; k < 3; k++) step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0, 8'hF1 + 8'(k), "R6 tick");
    step(1'b1, 2'd2, 8'h0C, 1'b0, 1'b0, 1'b0, 8'hF3, "R8 arm");
    step(1'b1, 2'd2, 8'h05, 1'b0, 1'b0, 1'b0, 8'hF3, "R8 bad");
    step(1'b1, 2'd2, 8'h03, 1'b0, 1'b0, 1'b0, 8'hF3, "R8 no reload");
    step(1'b1, 2'd2, 8'h0C, 1'b0, 1'b0, 1'b0, 8'hF3, "R8 rearm");
    step(1'b1, 2'd2, 8'h03, 1'b0, 1'b0, 1'b0, 8'hF0, "R8 reload");
    for (int k = 0; k < 15; k++) step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0, 8'hF1 + 8'(k), "R10 run up");
    step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b1, 8'hF0, "R10 timeout");
    for (int k = 0; k < 15; k++) step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0, 8'hF1 + 8'(k), "R12 run up");
    step(1'b1, 2'd2, 8'h0C, 1'b0, 1'b0, 1'b0, 8'hFF, "R12 arm");
    step(1'b1, 2'd2, 8'h03, 1'b1, 1'b0, 1'b0, 8'hF0, "R12 race");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule